// File: doc/BRIEF.md
# Two-Wire Slave Front End for a 10-Bit Current DAC

This block is the digital side of a current-sinking converter. It watches an oversampled two-wire serial bus (SCL/SDA) and answers a group of four 7-bit addresses. It takes in a 16-bit command word and hands a 10-bit code and a power-down request to the analog core. Both bus lines pass through a two-stage synchronizer and a stability counter. Any pulse shorter than the filter window is dropped before the protocol logic sees it.

A write is an address byte with the direction bit clear, followed by exactly two data bytes. Bits go out high byte first, MSB first, into a 16-bit input register. Only after the sixteenth bit is complete does the register load the code and the soft power-down flag. A read sends back the input register in the same layout. When the second byte of a read has gone out, the input register is cleared to zero. The power-down output is the OR of an asynchronous pin and the soft flag.

The protocol engine is one state machine with these states:
- IDLE: the bus is free.
- ADDR: the address byte is being shifted in.
- ADDR_ACK: the slave drives the address acknowledge.
- WR_BYTE: a data byte is being received.
- WR_ACK: the slave drives the data acknowledge.
- RD_BYTE: the slave is sending a byte.
- RD_ACK: the slave samples the master's acknowledge.
- IGNORE: the slave ignores the bus until the next START or STOP.

The transitions are:
- start_seen: any state to ADDR.
- stop_seen: any state to IDLE.
- addr_hit: ADDR to ADDR_ACK.
- addr_miss: ADDR to IGNORE.
- ack_done_wr: ADDR_ACK to WR_BYTE.
- ack_done_rd: ADDR_ACK to RD_BYTE.
- byte_in: WR_BYTE to WR_ACK.
- next_wr: WR_ACK back to WR_BYTE.
- word_done: WR_ACK to IGNORE.
- byte_out: RD_BYTE to RD_ACK.
- next_rd: RD_ACK back to RD_BYTE.
- read_end: RD_ACK to IGNORE, taken on a NACK or after the second byte.

Top module: `dac_i2c_slave`

## Requirements
- R1: After reset, the code output is 0, the soft power-down flag is clear and SDA is released (sda_drive_low = 0).
- R2: An address byte whose upper five bits are 00011 is acknowledged, whatever its bits 2:1 are. Byte values 0x18 to 0x1F select the device: bit 0 = 0 means write and bit 0 = 1 means read. Any other address gets no acknowledge, and the slave stays silent until the next START or STOP.
- R3: After a matching address byte and after each of the two write data bytes, SDA is held low through the ninth SCL pulse.
- R4: In the 16-bit word, bit 15 is the soft power-down (1 = down) and bits 13:4 are the code, D9 to D0. Bits 14 and 3:0 are ignored.
- R5: The code and the soft flag change only when the sixteenth data bit of a write completes. A write stopped after one byte leaves both unchanged.
- R6: A read returns the input register as two bytes, high byte first and MSB first, in the same layout as a write.
- R7: When the second byte of a read has been sent, the input register is zero, so the next read returns 0x00 0x00. The code is not affected.
- R8: A master NACK after the first read byte ends the transfer: SDA is released, the code is unchanged and the input register keeps its contents.
- R9: pwr_down is high whenever pd_pin is high or the soft flag is set. It follows pd_pin without any clock.
- R10: A pulse on SCL or SDA lasting fewer than FILT_CYCLES clock cycles has no effect on the protocol.
- R11: A repeated START in the middle of a transfer restarts address reception. A following complete write takes effect.
- R12: The slave changes its SDA drive only while SCL is low.
- R13: A third data byte in a write is not acknowledged and does not change the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (the resolved wired-AND level) |
| pd_pin | input | 1 | Asynchronous power-down request, active high |
| sda_drive_low | output | 1 | 1 = pull SDA low (open-drain enable) |
| dac_code | output | 10 | Code for the converter core |
| pwr_down | output | 1 | Effective power-down: pd_pin OR the soft flag |

## Verification
The checker watches four things on every clock:
- pd_pin always forces pwr_down.
- The SDA drive never changes while the filtered SCL is high.
- The drive is released whenever the bus is idle or ignored.
- The code register moves only on the last bit of the second write byte.

An address acknowledge can occur only after a matching address byte. The bench's own scenarios are needed for the rest:
- the actual bit layout of writes and read-back;
- the clearing of the input register after a read;
- early termination on a NACK;
- a repeated START;
- a third byte that is not acknowledged;
- rejection of a short SCL spike.

Each of these is seen as a bus-level result.

// File: rtl/dac_i2c_pkg.sv
package dac_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } dac_bus_st_e;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int STABLE_CYC  = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CNT_W = $clog2(STABLE_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '1;
            cnt_q   <= '0;
            clean_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            if (synced == clean_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_W'(STABLE_CYC - 1)) begin
                clean_o <= synced;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise = scl_i & ~scl_q;
    assign scl_fall = ~scl_i & scl_q;
    assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/dac_i2c_slave.sv
module dac_i2c_slave
    import dac_i2c_pkg::*;
#(
    parameter int         FILT_CYCLES = 5,
    parameter int         CODE_W      = 10,
    parameter logic [4:0] DEV_ADDR_HI = 5'b00011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              pd_pin,
    output logic              sda_drive_low,
    output logic [CODE_W-1:0] dac_code,
    output logic              pwr_down
);
    localparam int WORD_W   = 16;
    localparam int CODE_LSB = 4;
    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;
    localparam int PD_BIT   = WORD_W - 1;
    localparam int NLINES   = 2;

    // line filters: index 1 = SCL, index 0 = SDA
    logic [NLINES-1:0] raw_lines, clean_lines;
    logic scl_flt, sda_flt;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        i2c_line_filter #(.STABLE_CYC(FILT_CYCLES)) filt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_lines[g]),
            .clean_o (clean_lines[g])
        );
    end

    assign scl_flt = clean_lines[1];
    assign sda_flt = clean_lines[0];

    logic scl_rise, scl_fall, start_ev, stop_ev;

    i2c_cond_detect cond_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_flt),
        .sda_i    (sda_flt),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    dac_bus_st_e       st_q, st_d;
    logic [3:0]        bit_cnt_q;
    logic              byte_idx_q;
    logic              nack_q;
    logic [7:0]        addr_sh_q;
    logic [WORD_W-1:0] inreg_q;
    logic [WORD_W-1:0] rd_sh_q;
    logic [CODE_W-1:0] dac_code_q;
    logic              soft_pd_q;
    logic              addr_hit;

    assign addr_hit = (addr_sh_q[7:3] == DEV_ADDR_HI);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (stop_ev) begin
            st_d = ST_IDLE;
        end else if (start_ev) begin
            st_d = ST_ADDR;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_IGNORE: ;
                ST_ADDR:     if (scl_fall && bit_cnt_q == 4'd8)
                                 st_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)
                                 st_d = addr_sh_q[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && bit_cnt_q == 4'd8)
                                 st_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall)
                                 st_d = byte_idx_q ? ST_IGNORE : ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bit_cnt_q == 4'd7)
                                 st_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)
                                 st_d = (nack_q || byte_idx_q) ? ST_IGNORE : ST_RD_BYTE;
                default:     st_d = ST_IDLE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            byte_idx_q <= 1'b0;
            nack_q     <= 1'b0;
            addr_sh_q  <= '0;
            inreg_q    <= '0;
            rd_sh_q    <= '0;
            dac_code_q <= '0;
            soft_pd_q  <= 1'b0;
        end else if (start_ev || stop_ev) begin
            bit_cnt_q  <= '0;
            byte_idx_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_ADDR: if (scl_rise) begin
                    addr_sh_q <= {addr_sh_q[6:0], sda_flt};
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    bit_cnt_q  <= '0;
                    byte_idx_q <= 1'b0;
                    rd_sh_q    <= inreg_q;
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        inreg_q   <= {inreg_q[WORD_W-2:0], sda_flt};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                    if (scl_fall && bit_cnt_q == 4'd8 && byte_idx_q) begin
                        dac_code_q <= inreg_q[CODE_MSB:CODE_LSB];
                        soft_pd_q  <= inreg_q[PD_BIT];
                    end
                end
                ST_WR_ACK: if (scl_fall) begin
                    bit_cnt_q  <= '0;
                    byte_idx_q <= 1'b1;
                end
                ST_RD_BYTE: if (scl_fall) begin
                    rd_sh_q   <= {rd_sh_q[WORD_W-2:0], 1'b0};
                    bit_cnt_q <= (bit_cnt_q == 4'd7) ? 4'd0 : bit_cnt_q + 1'b1;
                end
                ST_RD_ACK: begin
                    if (scl_rise) nack_q <= sda_flt;
                    if (scl_fall) begin
                        byte_idx_q <= 1'b1;
                        if (byte_idx_q) inreg_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_drive_low = (st_q == ST_ADDR_ACK) || (st_q == ST_WR_ACK) ||
                        ((st_q == ST_RD_BYTE) && !rd_sh_q[WORD_W-1]);
        dac_code      = dac_code_q;
        pwr_down      = pd_pin | soft_pd_q;
    end
endmodule

// File: rtl/dac_i2c_slave_chk.sv
module dac_i2c_slave_chk
    import dac_i2c_pkg::*;
#(
    parameter logic [4:0] ADDR_HI = 5'b00011,
    parameter int         CODE_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pd_pin,
    input logic              pwr_down,
    input logic              sda_drive_low,
    input logic              scl_f,
    input logic              byte_idx,
    input logic [7:0]        addr_q,
    input logic [CODE_W-1:0] dac_code,
    input dac_bus_st_e       st
);
    AST_PD_PIN_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        pd_pin |-> pwr_down); // R9

    AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f)) |-> $stable(sda_drive_low)); // R12

    AST_RELEASED_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_IGNORE) |-> !sda_drive_low); // R2

    AST_ACK_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR_ACK) |-> (addr_q[7:3] == ADDR_HI)); // R2

    AST_CODE_ON_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code != $past(dac_code)) |-> ($past(st) == ST_WR_BYTE && $past(byte_idx))); // R5
endmodule

bind dac_i2c_slave dac_i2c_slave_chk #(
    .ADDR_HI (DEV_ADDR_HI),
    .CODE_W  (CODE_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pd_pin        (pd_pin),
    .pwr_down      (pwr_down),
    .sda_drive_low (sda_drive_low),
    .scl_f         (scl_flt),
    .byte_idx      (byte_idx_q),
    .addr_q        (addr_sh_q),
    .dac_code      (dac_code),
    .st            (st_q)
);

// File: tb/dac_i2c_slave_tb_top.sv
module dac_i2c_slave_tb_top;
    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pd_pin = 1'b0;
    logic       sda_drive_low;
    logic [9:0] dac_code;
    logic       pwr_down;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_drive_low;

    dac_i2c_slave dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_m),
        .sda_i         (sda_bus),
        .pd_pin        (pd_pin),
        .sda_drive_low (sda_drive_low),
        .dac_code      (dac_code),
        .pwr_down      (pwr_down)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        tick(Q); sda_m = 1'b1;
        tick(Q); scl_m = 1'b1;
        tick(2*Q); sda_m = 1'b0;
        tick(2*Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0;
        tick(Q); scl_m = 1'b1;
        tick(2*Q); sda_m = 1'b1;
        tick(2*Q);
    endtask

    task automatic clk_bit(input bit d, input bit glitch, output bit s1, output bit s2);
        tick(Q); sda_m = d;
        if (glitch) begin
            tick(4); scl_m = 1'b1;
            tick(2); scl_m = 1'b0;
            tick(Q-6);
        end else begin
            tick(Q);
        end
        scl_m = 1'b1;
        tick(Q);   s1 = sda_bus;
        tick(Q-2); s2 = sda_bus;
        tick(2);   scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit nak);
        bit s1, s2;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], glitch && (i == 7), s1, s2);
        clk_bit(1'b1, 1'b0, s1, s2);
        nak = s1;
    endtask

    task automatic recv_byte(input bit m_nak, output logic [7:0] b, output bit steady);
        bit s1, s2;
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, 1'b0, s1, s2);
            b[i] = s1;
            if (s1 != s2) steady = 1'b0;
        end
        clk_bit(m_nak, 1'b0, s1, s2);
    endtask

    task automatic write_word(input logic [7:0] a, input logic [7:0] hi,
                              input logic [7:0] lo, input string req);
        bit n0, n1, n2;
        bus_start();
        send_byte(a, 1'b0, n0);
        send_byte(hi, 1'b0, n1);
        send_byte(lo, 1'b0, n2);
        bus_stop();
        chk({req, " R2 address ack"}, n0, 0);
        chk({req, " R3 data acks"}, {n1, n2}, 0);
    endtask

    task automatic read_word(input logic [7:0] a, input bit early_nak,
                             output logic [7:0] hi, output logic [7:0] lo);
        bit n0, st1, st2;
        lo = 8'h00;
        bus_start();
        send_byte(a, 1'b0, n0);
        chk("R2 read address ack", n0, 0);
        recv_byte(early_nak, hi, st1);
        st2 = 1'b1;
        if (!early_nak) recv_byte(1'b1, lo, st2);
        bus_stop();
        chk("R12 SDA steady while SCL high", st1 & st2, 1);
    endtask

    task automatic t_reset();
        chk("R1 code after reset", dac_code, 0);
        chk("R1 pwr_down after reset", pwr_down, 0);
        chk("R1 SDA released", sda_drive_low, 0);
        pd_pin = 1'b1; #1;
        chk("R9 pin forces pwr_down", pwr_down, 1);
        pd_pin = 1'b0; #1;
        chk("R9 pin released", pwr_down, 0);
    endtask

    task automatic t_basic_write();
        write_word(8'h18, 8'h5A, 8'hCF, "basic");
        chk("R4 code layout", dac_code, 10'h1AC);
        chk("R4 soft pd clear", pwr_down, 0);
    endtask

    task automatic t_soft_pd();
        write_word(8'h1E, 8'hBF, 8'hF0, "softpd");
        chk("R4 full-scale code", dac_code, 10'h3FF);
        chk("R9 soft pd sets pwr_down", pwr_down, 1);
        write_word(8'h1A, 8'h00, 8'h00, "zero");
        chk("R4 zero code", dac_code, 0);
        chk("R9 soft pd cleared", pwr_down, 0);
    endtask

    task automatic t_mismatch();
        bit n0, n1, n2;
        write_word(8'h1C, 8'h01, 8'h00, "alias");
        chk("R2 alias 0x1C writes", dac_code, 10'h010);
        bus_start();
        send_byte(8'h20, 1'b0, n0);
        send_byte(8'h3F, 1'b0, n1);
        send_byte(8'hF0, 1'b0, n2);
        bus_stop();
        chk("R2 foreign address not acked", n0, 1);
        chk("R2 ignored data not acked", {n1, n2}, 2'b11);
        chk("R2 code unchanged after foreign write", dac_code, 10'h010);
        bus_start();
        send_byte(8'h16, 1'b0, n0);
        bus_stop();
        chk("R2 address 0x16 not acked", n0, 1);
    endtask

    task automatic t_partial();
        bit n0, n1;
        bus_start();
        send_byte(8'h18, 1'b0, n0);
        send_byte(8'h7F, 1'b0, n1);
        bus_stop();
        chk("R5 partial write acks", {n0, n1}, 0);
        chk("R5 code unchanged after partial write", dac_code, 10'h010);
    endtask

    task automatic t_read_clear();
        logic [7:0] hi, lo;
        write_word(8'h18, 8'h41, 8'h23, "preread");
        chk("R4 code before read", dac_code, 10'h012);
        read_word(8'h19, 1'b0, hi, lo);
        chk("R6 read high byte", hi, 8'h41);
        chk("R6 read low byte", lo, 8'h23);
        read_word(8'h1D, 1'b0, hi, lo);
        chk("R7 cleared high byte", hi, 0);
        chk("R7 cleared low byte", lo, 0);
        chk("R7 code kept after read", dac_code, 10'h012);
    endtask

    task automatic t_nack();
        logic [7:0] hi, lo;
        write_word(8'h1A, 8'h3C, 8'h9F, "prenack");
        read_word(8'h1B, 1'b1, hi, lo);
        chk("R8 first byte before NACK", hi, 8'h3C);
        chk("R8 SDA released after NACK", sda_drive_low, 0);
        chk("R8 code unchanged", dac_code, 10'h3C9);
        read_word(8'h1F, 1'b0, hi, lo);
        chk("R8 register kept high", hi, 8'h3C);
        chk("R8 register kept low", lo, 8'h9F);
    endtask

    task automatic t_repstart();
        bit n0, n1, n2, n3, n4;
        bus_start();
        send_byte(8'h18, 1'b0, n0);
        send_byte(8'h12, 1'b0, n1);
        bus_start();
        send_byte(8'h18, 1'b0, n2);
        send_byte(8'h33, 1'b0, n3);
        send_byte(8'h50, 1'b0, n4);
        bus_stop();
        chk("R11 acks across repeated START", {n0, n1, n2, n3, n4}, 0);
        chk("R11 code after repeated START", dac_code, 10'h335);
    endtask

    task automatic t_third_byte();
        bit n0, n1, n2, n3;
        bus_start();
        send_byte(8'h18, 1'b0, n0);
        send_byte(8'h00, 1'b0, n1);
        send_byte(8'h10, 1'b0, n2);
        send_byte(8'hFF, 1'b0, n3);
        bus_stop();
        chk("R13 first three bytes acked", {n0, n1, n2}, 0);
        chk("R13 third data byte not acked", n3, 1);
        chk("R13 code from first two bytes", dac_code, 10'h001);
    endtask

    task automatic t_glitch();
        bit n0, n1, n2;
        bus_start();
        send_byte(8'h18, 1'b0, n0);
        send_byte(8'h05, 1'b1, n1);
        send_byte(8'h50, 1'b0, n2);
        bus_stop();
        chk("R10 acks with SCL spike", {n0, n1, n2}, 0);
        chk("R10 code with SCL spike", dac_code, 10'h055);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_basic_write();
        t_soft_pd();
        t_mismatch();
        t_partial();
        t_read_clear();
        t_nack();
        t_repstart();
        t_third_byte();
        t_glitch();
        finish_run();
    end
endmodule